// File: doc/BRIEF.md
# Shadow Register Command Issuer

This block sits on the host side of a serial storage link. It holds the legacy task-file registers that software programs before it issues a command. Software writes single bytes through a plain register-write port. A write to the command byte or to the control byte copies the whole register set into a five-doubleword host-to-device register frame. The frame goes out to the transport layer one doubleword per beat.

Features, sector count and the three address bytes each hold two bytes, to support 48-bit addressing. A new write moves the current value into the expanded (upper) byte. The device select, command and control bytes hold one byte each.

A status byte follows the device. A command write sets its busy bit. A status-update input loads a new byte in place of the device's reply. While the busy bit or the data-request bit is set, the parameter registers are locked.

The frame leaves on a valid/ready stream with these back-pressure rules:
- A beat transfers on a cycle where `fis_valid` and `fis_ready` are both high.
- While `fis_ready` is low, `fis_valid` and `fis_data` stay unchanged.
- `fis_ready` may be held low for any number of cycles. Nothing is lost.

Top module: `tf_cmd_issuer`

## Requirements
- R1: After reset the status byte is 00h, `fis_valid` is low and every shadow byte is zero.
- R2: Register addresses are 0 features, 1 sector count, 2 address bits 7:0, 3 address bits 15:8, 4 address bits 23:16, 5 device, 6 command and 7 control. A write to addresses 0 to 4 moves the current byte into that register's expanded byte and stores the new byte as the current value.
- R3: An accepted command write sends one frame. Its first doubleword is {features, command, flag byte, 27h}. Bit 7 of the flag byte is 1 and all its other bits are 0.
- R4: Doublewords 1 to 4 of a frame are as follows:
  - doubleword 1: {device, addr 23:16, addr 15:8, addr 7:0};
  - doubleword 2: {features expanded, addr 47:40, addr 39:32, addr 31:24};
  - doubleword 3: {control, 00h, count expanded, count};
  - doubleword 4: zero.
- R5: A control write is always accepted, even while busy. It stores the control byte and sends a frame whose flag bit is 0.
- R6: Status bit 7 (busy) reads 1 in the cycle after an accepted command write. The first beat of the frame is offered one cycle later.
- R7: While status bit 7 or status bit 3 (data request) is set, writes to addresses 0 to 6 have no effect.
- R8: A status update replaces the whole status byte. Busy clears only through an update that carries bit 7 = 0.
- R9: While `fis_valid` is high and `fis_ready` is low, the beat is held unchanged. Each frame is exactly 5 beats, and `fis_last` marks the fifth.
- R10: Control writes made while a frame is pending or in flight produce exactly one further control frame. That frame is sent after the current one and carries the newest control byte.
- R11: A command write made while a frame is pending or in flight is ignored: busy does not rise and no frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (see R2) |
| wr_data | input | 8 | Register write byte |
| stat_upd_valid | input | 1 | Load a new status byte |
| stat_upd_data | input | 8 | New status byte from the device side |
| status | output | 8 | Current status byte (bit 7 busy, bit 3 data request) |
| fis_valid | output | 1 | Frame beat valid |
| fis_ready | input | 1 | Transport accepts the beat |
| fis_data | output | 32 | Frame doubleword |
| fis_last | output | 1 | Fifth beat of a frame |

## Verification
The bench targets the lock window:
- a write landing while busy or data request is set must leave the frame unchanged, otherwise the next frame shows the stray byte;
- a command write during a control frame must leave busy low, otherwise the design issues a frame the host never asked for.

Back-pressure is held mid-frame while two control writes arrive. Correct behaviour is a command frame still carrying the old control byte, followed by exactly one control frame with the newer byte. A design that snapshots late, or that queues each control write separately, shows either a wrong byte or a sixth frame. The two-deep shift is checked through the expanded doubleword after repeated writes.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int BYTE_W      = 8;
  localparam int WORD_W      = 32;
  localparam int FRAME_WORDS = 5;
  localparam int IDX_W       = $clog2(FRAME_WORDS);
  localparam int ADDR_W      = 3;
  localparam int NUM_DEEP    = 5;
  localparam int BSY_BIT     = 7;
  localparam int DRQ_BIT     = 3;
  localparam logic [BYTE_W-1:0] TYPE_H2D = 8'h27;

  typedef enum logic [ADDR_W-1:0] {
    A_FEAT = 3'd0, A_CNT = 3'd1, A_LBA0 = 3'd2, A_LBA1 = 3'd3,
    A_LBA2 = 3'd4, A_DEV = 3'd5, A_CMD = 3'd6, A_CTL = 3'd7
  } tf_addr_e;

  typedef struct packed {
    logic [BYTE_W-1:0] feat, feat_x;
    logic [BYTE_W-1:0] cnt, cnt_x;
    logic [BYTE_W-1:0] lba0, lba1, lba2;
    logic [BYTE_W-1:0] lba0_x, lba1_x, lba2_x;
    logic [BYTE_W-1:0] dev, cmd, ctl;
  } tf_regs_t;

  function automatic logic [WORD_W-1:0] frame_word(tf_regs_t r, logic is_cmd,
                                                   logic [IDX_W-1:0] idx);
    logic [WORD_W-1:0] w;
    case (idx)
      3'd0:    w = {r.feat, r.cmd, is_cmd, 7'b0, TYPE_H2D};
      3'd1:    w = {r.dev, r.lba2, r.lba1, r.lba0};
      3'd2:    w = {r.feat_x, r.lba2_x, r.lba1_x, r.lba0_x};
      3'd3:    w = {r.ctl, 8'h00, r.cnt_x, r.cnt};
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/tf_shadow_bank.sv
module tf_shadow_bank
  import tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              lock,
  input  logic              tx_busy,
  output tf_regs_t          regs,
  output logic              cmd_fire,
  output logic              ctl_fire
);
  logic [NUM_DEEP-1:0][BYTE_W-1:0] cur_v, xp_v;
  logic [BYTE_W-1:0] dev_q, cmd_q, ctl_q;

  // two-deep parameter bytes, addresses 0..NUM_DEEP-1
  for (genvar gi = 0; gi < NUM_DEEP; gi++) begin : g_deep
    logic [BYTE_W-1:0] cur_q, xp_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur_q <= '0;
        xp_q  <= '0;
      end else if (wr_en && !lock && wr_addr == ADDR_W'(gi)) begin
        xp_q  <= cur_q;
        cur_q <= wr_data;
      end
    end
    assign cur_v[gi] = cur_q;
    assign xp_v[gi]  = xp_q;
  end

  assign cmd_fire = wr_en && wr_addr == A_CMD && !lock && !tx_busy;
  assign ctl_fire = wr_en && wr_addr == A_CTL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_q <= '0;
      cmd_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_DEV && !lock) dev_q <= wr_data;
      if (cmd_fire) cmd_q <= wr_data;
      if (ctl_fire) ctl_q <= wr_data;
    end
  end

  always_comb begin
    regs.feat   = cur_v[A_FEAT];
    regs.feat_x = xp_v[A_FEAT];
    regs.cnt    = cur_v[A_CNT];
    regs.cnt_x  = xp_v[A_CNT];
    regs.lba0   = cur_v[A_LBA0];
    regs.lba1   = cur_v[A_LBA1];
    regs.lba2   = cur_v[A_LBA2];
    regs.lba0_x = xp_v[A_LBA0];
    regs.lba1_x = xp_v[A_LBA1];
    regs.lba2_x = xp_v[A_LBA2];
    regs.dev    = dev_q;
    regs.cmd    = cmd_q;
    regs.ctl    = ctl_q;
  end
endmodule

// File: rtl/tf_status.sv
module tf_status
  import tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic              upd_valid,
  input  logic [BYTE_W-1:0] upd_data,
  output logic [BYTE_W-1:0] status,
  output logic              lock
);
  logic [BYTE_W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      if (upd_valid) stat_q <= upd_data;
      if (cmd_fire)  stat_q[BSY_BIT] <= 1'b1;  // a new command wins busy
    end
  end

  assign status = stat_q;
  assign lock   = stat_q[BSY_BIT] | stat_q[DRQ_BIT];
endmodule

// File: rtl/tf_frame_tx.sv
module tf_frame_tx
  import tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic              ctl_fire,
  input  tf_regs_t          regs,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic              last,
  output logic              tx_busy
);
  tf_regs_t         snap_q;
  logic             flag_q, valid_q, pend_cmd_q, pend_ctl_q;
  logic [IDX_W-1:0] idx_q;
  logic             fire, last_beat, load_now, load_cmd;

  assign fire      = valid_q && ready;
  assign last_beat = idx_q == IDX_W'(FRAME_WORDS - 1);
  assign load_now  = (!valid_q || (fire && last_beat)) && (pend_cmd_q || pend_ctl_q);
  assign load_cmd  = pend_cmd_q;  // command frame goes ahead of a queued control

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q     <= '0;
      flag_q     <= 1'b0;
      valid_q    <= 1'b0;
      idx_q      <= '0;
      pend_cmd_q <= 1'b0;
      pend_ctl_q <= 1'b0;
    end else begin
      pend_cmd_q <= (pend_cmd_q && !(load_now && load_cmd)) || cmd_fire;
      pend_ctl_q <= (pend_ctl_q && !(load_now && !load_cmd)) || ctl_fire;
      if (load_now) begin
        snap_q  <= regs;
        flag_q  <= load_cmd;
        valid_q <= 1'b1;
        idx_q   <= '0;
      end else if (fire) begin
        if (last_beat) valid_q <= 1'b0;
        else           idx_q   <= idx_q + 1'b1;
      end
    end
  end

  assign valid   = valid_q;
  assign data    = frame_word(snap_q, flag_q, idx_q);
  assign last    = valid_q && last_beat;
  assign tx_busy = valid_q || pend_cmd_q || pend_ctl_q;
endmodule

// File: rtl/tf_cmd_issuer.sv
module tf_cmd_issuer
  import tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              stat_upd_valid,
  input  logic [BYTE_W-1:0] stat_upd_data,
  output logic [BYTE_W-1:0] status,
  output logic              fis_valid,
  input  logic              fis_ready,
  output logic [WORD_W-1:0] fis_data,
  output logic              fis_last
);
  tf_regs_t regs_w;
  logic     lock_w, tx_busy_w, cmd_fire_w, ctl_fire_w;

  tf_shadow_bank bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lock(lock_w), .tx_busy(tx_busy_w),
    .regs(regs_w), .cmd_fire(cmd_fire_w), .ctl_fire(ctl_fire_w)
  );

  tf_status stat_i (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire_w),
    .upd_valid(stat_upd_valid), .upd_data(stat_upd_data),
    .status(status), .lock(lock_w)
  );

  tf_frame_tx tx_i (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire_w), .ctl_fire(ctl_fire_w),
    .regs(regs_w), .ready(fis_ready), .valid(fis_valid), .data(fis_data),
    .last(fis_last), .tx_busy(tx_busy_w)
  );
endmodule

// File: rtl/tf_cmd_issuer_chk.sv
module tf_cmd_issuer_chk
  import tf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              stat_upd_valid,
  input logic [BYTE_W-1:0] stat_upd_data,
  input logic [BYTE_W-1:0] status,
  input logic              fis_valid,
  input logic              fis_ready,
  input logic [WORD_W-1:0] fis_data,
  input logic              fis_last,
  input logic              lock,
  input logic              tx_busy,
  input tf_regs_t          regs
);
  logic [IDX_W-1:0] beat_q;
  always_ff @(posedge clk) begin
    if (!rst_n) beat_q <= '0;
    else if (fis_valid && fis_ready)
      beat_q <= (beat_q == IDX_W'(FRAME_WORDS - 1)) ? '0 : beat_q + 1'b1;
  end

  a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    fis_valid && !fis_ready |=> fis_valid && $stable(fis_data));
  a_r3_type_first: assert property (@(posedge clk) disable iff (!rst_n)
    fis_valid && beat_q == '0 |-> fis_data[7:0] == TYPE_H2D);
  a_r4_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fis_valid && beat_q == IDX_W'(FRAME_WORDS - 1) |-> fis_data == '0 && fis_last);
  a_r6_bsy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_CMD && !lock && !tx_busy |=> status[BSY_BIT]);
  a_r7_locked_feat: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_FEAT && lock |=> $stable(regs.feat) && $stable(regs.feat_x));
  a_r8_bsy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_upd_valid && !stat_upd_data[BSY_BIT] && !(wr_en && wr_addr == A_CMD)
    |=> !status[BSY_BIT]);
  a_r11_cmd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_CMD && tx_busy |=> $stable(regs.cmd));
endmodule

bind tf_cmd_issuer tf_cmd_issuer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .stat_upd_valid(stat_upd_valid), .stat_upd_data(stat_upd_data),
  .status(status), .fis_valid(fis_valid), .fis_ready(fis_ready),
  .fis_data(fis_data), .fis_last(fis_last), .lock(lock_w),
  .tx_busy(tx_busy_w), .regs(regs_w)
);

// File: tb/tf_cmd_issuer_tb_top.sv
module tf_cmd_issuer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        stat_upd_valid = 1'b0;
  logic [7:0]  stat_upd_data = '0;
  logic [7:0]  status;
  logic        fis_valid, fis_ready = 1'b0, fis_last;
  logic [31:0] fis_data;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [7:0] m_cur [5];
  logic [7:0] m_xp  [5];
  logic [7:0] m_dev, m_cmd, m_ctl, m_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  tf_cmd_issuer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_upd_valid(stat_upd_valid), .stat_upd_data(stat_upd_data),
    .status(status), .fis_valid(fis_valid), .fis_ready(fis_ready),
    .fis_data(fis_data), .fis_last(fis_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0][31:0] exp_frame(input logic flag);
    logic [4:0][31:0] w;
    w[0] = {m_cur[0], m_cmd, flag, 7'b0, 8'h27};
    w[1] = {m_dev, m_cur[4], m_cur[3], m_cur[2]};
    w[2] = {m_xp[0], m_xp[4], m_xp[3], m_xp[2]};
    w[3] = {m_ctl, 8'h00, m_xp[1], m_cur[1]};
    w[4] = 32'h0;
    return w;
  endfunction

  // bench-side acceptance model; txb tells whether a frame is outstanding
  task automatic write_reg(input logic [2:0] a, input logic [7:0] d, input logic txb,
                           output logic trig_cmd, output logic trig_ctl);
    logic locked;
    locked = m_st[7] | m_st[3];
    trig_cmd = 1'b0;
    trig_ctl = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 3'd5) begin
      if (!locked) begin m_xp[a] = m_cur[a]; m_cur[a] = d; end
    end else if (a == 3'd5) begin
      if (!locked) m_dev = d;
    end else if (a == 3'd6) begin
      if (!locked && !txb) begin m_cmd = d; m_st[7] = 1'b1; trig_cmd = 1'b1; end
    end else begin
      m_ctl = d; trig_ctl = 1'b1;
    end
  endtask

  task automatic stat_update(input logic [7:0] d);
    @(negedge clk);
    stat_upd_valid = 1'b1; stat_upd_data = d;
    @(negedge clk);
    stat_upd_valid = 1'b0;
    m_st = d;
    check("R8 status replaced", {24'h0, status}, {24'h0, d});
  endtask

  task automatic collect(input string req, input logic [4:0][31:0] w);
    int b = 0, guard = 0;
    logic held = 1'b0;
    logic [31:0] hv = '0;
    while (b < 5 && guard < 400) begin
      @(negedge clk);
      guard++;
      if (held) check("R9 beat held under back-pressure", fis_data, hv);
      fis_ready = ($urandom % 4) != 0;
      if (fis_valid) begin
        if (fis_ready) begin
          check(req, fis_data, w[b]);
          check("R9 last marker", {31'h0, fis_last}, {31'h0, b == 4});
          b++;
          held = 1'b0;
        end else begin
          held = 1'b1;
          hv = fis_data;
        end
      end else held = 1'b0;
    end
    if (b < 5) check({req, " frame timeout"}, b, 5);
    @(negedge clk);
    fis_ready = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    fis_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(req, {31'h0, fis_valid}, 32'h0);
    fis_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic tc, tl;
    logic [4:0][31:0] w;
    void'($urandom(32'd4711));
    for (int i = 0; i < 5; i++) begin m_cur[i] = '0; m_xp[i] = '0; end
    m_dev = '0; m_cmd = '0; m_ctl = '0; m_st = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", {24'h0, status}, 32'h0);
    check("R1 valid after reset", {31'h0, fis_valid}, 32'h0);

    // R1/R5: control frame right after reset shows all-zero shadow
    write_reg(3'd7, 8'h00, 1'b0, tc, tl);
    collect("R1 R5 reset frame", exp_frame(1'b0));
    expect_idle("R10 single control frame");

    // R2: two-deep shift on features and count
    write_reg(3'd0, 8'h11, 1'b0, tc, tl);
    write_reg(3'd0, 8'h22, 1'b0, tc, tl);
    write_reg(3'd1, 8'h33, 1'b0, tc, tl);
    write_reg(3'd1, 8'h44, 1'b0, tc, tl);
    write_reg(3'd5, 8'hE5, 1'b0, tc, tl);
    write_reg(3'd6, 8'h25, 1'b0, tc, tl);
    check("R6 busy one cycle after command", {31'h0, status[7]}, 32'h1);
    check("R6 frame not yet offered", {31'h0, fis_valid}, 32'h0);
    collect("R2 R3 R4 command frame", exp_frame(1'b1));
    expect_idle("R3 one frame per command");

    // R7: writes while busy are ignored, seen in the next control frame
    write_reg(3'd0, 8'h99, 1'b0, tc, tl);
    write_reg(3'd5, 8'hA0, 1'b0, tc, tl);
    write_reg(3'd6, 8'hEC, 1'b0, tc, tl);
    check("R7 command ignored while busy", {31'h0, fis_valid}, 32'h0);
    write_reg(3'd7, 8'h04, 1'b0, tc, tl);
    collect("R5 R7 control frame while busy", exp_frame(1'b0));
    expect_idle("R7 no command frame while busy");

    // R8: DRQ alone locks; clearing update unlocks
    stat_update(8'h08);
    write_reg(3'd2, 8'h77, 1'b0, tc, tl);
    stat_update(8'h50);
    check("R8 busy cleared", {31'h0, status[7]}, 32'h0);

    // R10: two control writes during a held command frame
    write_reg(3'd6, 8'h35, 1'b0, tc, tl);
    w = exp_frame(1'b1);
    write_reg(3'd7, 8'h02, 1'b1, tc, tl);
    write_reg(3'd7, 8'h00, 1'b1, tc, tl);
    collect("R10 command frame keeps old control", w);
    collect("R10 merged control frame", exp_frame(1'b0));
    expect_idle("R10 exactly one queued frame");

    // R11: command during a control frame is dropped
    stat_update(8'h40);
    write_reg(3'd7, 8'h08, 1'b0, tc, tl);
    write_reg(3'd6, 8'hC8, 1'b1, tc, tl);
    check("R11 busy stays low", {31'h0, status[7]}, 32'h0);
    collect("R11 control frame", exp_frame(1'b0));
    expect_idle("R11 no command frame");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 10;
      if (op < 6) begin
        write_reg(3'($urandom % 8), 8'($urandom), 1'b0, tc, tl);
        if (tc) check("R6 busy after random command", {31'h0, status[7]}, 32'h1);
        if (tc || tl) begin
          collect(tc ? "R3 R4 random command frame" : "R5 random control frame",
                  exp_frame(tc));
          expect_idle("R9 frame ends");
        end
      end else if (op < 8) begin
        logic [7:0] s;
        s = 8'($urandom);
        s[7] = ($urandom % 10) < 3;
        s[3] = ($urandom % 10) < 2;
        stat_update(s);
      end else begin
        @(negedge clk);
        check("R8 status holds", {24'h0, status}, {24'h0, m_st});
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule